// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is an eight-pin general-purpose I/O port reached through a small register interface. A per-pin direction register selects whether each pad drives the stored output value or floats as an input. An output latch holds the value to be driven. A pin-read address returns the synchronized pad levels. The latch has its own read path, so software can run a read-modify-write sequence on it without picking up pin levels that external loads have pulled away from the intended value.

A control register lets two other functions take the pads away from plain I/O. While the external bus is enabled, the pads carry the low byte of a multiplexed address/data bus and follow the bus-side enable and data inputs. When the bus is disabled and the slave-port bit is set, a parallel slave port drives the pads. Taking the pads over changes neither the direction register nor the latch. Synchronized pad levels are always available to whichever function owns the pins.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0xFF (all pins inputs), the latch reads 0x00, the control register reads 0x01, and pad_oe_o is 0x00.
- R2: In plain I/O mode each pad_oe_o bit is the inverse of its direction bit (1 = input, output driver off), and pad_out_o carries the latch value.
- R3: A read at address 1 returns the latch contents, not the pad levels, even when the two differ.
- R4: A read at address 0 returns pad_in_i delayed by two clock edges. After one edge the old level is still returned.
- R5: A write to address 0 or to address 1 loads wdata_i into the latch on the next clock edge.
- R6: A write to address 2 loads the direction register, and a read at address 2 returns it.
- R7: When control bit 0 (bus disable) is 0, pad_oe_o is ad_oe_i on all bits and pad_out_o is ad_out_i. The direction register and the latch keep their values.
- R8: When control bit 0 is 1 and control bit 1 (slave mode) is 1, pad_oe_o is psp_oe_i on all bits and pad_out_o is psp_out_i.
- R9: Bus mode takes priority: with bit 0 = 0, the pads follow the bus inputs whatever the value of bit 1.
- R10: Address 3 is the control register. Bits 0 and 1 are writable, and the other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe, one cycle |
| addr_i | input | 2 | Register address: 0 pins, 1 latch, 2 direction, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, 1 = drive |
| ad_oe_i | input | 1 | External bus output enable |
| ad_out_i | input | 8 | External bus output data |
| psp_oe_i | input | 1 | Slave port output enable |
| psp_out_i | input | 8 | Slave port output data |
| pin_sync_o | output | 8 | Synchronized pad levels for the owning function |

## Verification
Register traffic is applied with a pad level (0x3C) that differs from every value written to the latch. This separates the latch read from the pin read and shows that writes to the pin address land in the latch. A direction pattern that mixes inputs and outputs (0xCF) checks that each output enable tracks its own direction bit. A pad step from 0x3C to 0x96 is sampled after one edge and after two edges to pin down the synchronizer delay. Each of the four combinations of the two control bits is then applied, with bus and slave-port inputs set to distinct values, so that the pad outputs show which function owns the pins. Direction and latch are read back after bus mode to show they were left unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_PIN = 2'd0,
    REG_LAT = 2'd1,
    REG_DIR = 2'd2,
    REG_CTL = 2'd3
  } reg_addr_e;

  localparam int CTL_BUS_OFF_BIT = 0;
  localparam int CTL_SLAVE_BIT   = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // edges since reset, saturating; used only to bound the $past window
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R4
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] dir_o,
  output logic         bus_off_o,
  output logic         slave_o
);
  logic [W-1:0] lat_q, dir_q;
  logic         bus_off_q, slave_q;
  logic         lat_we, dir_we, ctl_we;

  assign lat_we = we_i && (addr_i == REG_PIN || addr_i == REG_LAT);
  assign dir_we = we_i && (addr_i == REG_DIR);
  assign ctl_we = we_i && (addr_i == REG_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q     <= '0;
      dir_q     <= '1;
      bus_off_q <= 1'b1;
      slave_q   <= 1'b0;
    end else begin
      if (lat_we) lat_q <= wdata_i;
      if (dir_we) dir_q <= wdata_i;
      if (ctl_we) begin
        bus_off_q <= wdata_i[CTL_BUS_OFF_BIT];
        slave_q   <= wdata_i[CTL_SLAVE_BIT];
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_PIN: rdata_o = pin_sync_i;
      REG_LAT: rdata_o = lat_q;
      REG_DIR: rdata_o = dir_q;
      default: begin
        rdata_o = '0;
        rdata_o[CTL_BUS_OFF_BIT] = bus_off_q;
        rdata_o[CTL_SLAVE_BIT]   = slave_q;
      end
    endcase
  end

  assign lat_o     = lat_q;
  assign dir_o     = dir_q;
  assign bus_off_o = bus_off_q;
  assign slave_o   = slave_q;

  AST_LAT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == REG_PIN || addr_i == REG_LAT)) |=> (lat_q == $past(wdata_i))); // R5
  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == REG_PIN || addr_i == REG_LAT)) |=> $stable(lat_q)); // R3
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == REG_DIR) |=> $stable(dir_q)); // R7
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 8
) (
  input  logic         bus_off_i,
  input  logic         slave_i,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] dir_i,
  input  logic         ad_oe_i,
  input  logic [W-1:0] ad_out_i,
  input  logic         psp_oe_i,
  input  logic [W-1:0] psp_out_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  // bus mode wins over slave mode
  logic use_bus, use_slave;
  assign use_bus   = !bus_off_i;
  assign use_slave = bus_off_i && slave_i;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (use_bus) begin
        pad_oe_o[i]  = ad_oe_i;
        pad_out_o[i] = ad_out_i[i];
      end else if (use_slave) begin
        pad_oe_o[i]  = psp_oe_i;
        pad_out_o[i] = psp_out_i[i];
      end else begin
        pad_oe_o[i]  = !dir_i[i];
        pad_out_o[i] = lat_i[i];
      end
    end
  end

  always_comb begin
    AST_INPUT_TRISTATED: assert (!(bus_off_i && !slave_i) || ((pad_oe_o & dir_i) == '0)); // R2
    AST_BUS_OWNS: assert (bus_off_i || (pad_out_o == ad_out_i && pad_oe_o == {W{ad_oe_i}})); // R9
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  input  logic         ad_oe_i,
  input  logic [W-1:0] ad_out_i,
  input  logic         psp_oe_i,
  input  logic [W-1:0] psp_out_i,
  output logic [W-1:0] pin_sync_o
);
  logic [W-1:0] lat, dir, pin_sync;
  logic         bus_off, slave;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pin_sync_i(pin_sync),
    .rdata_o   (rdata_o),
    .lat_o     (lat),
    .dir_o     (dir),
    .bus_off_o (bus_off),
    .slave_o   (slave)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .bus_off_i(bus_off),
    .slave_i  (slave),
    .lat_i    (lat),
    .dir_i    (dir),
    .ad_oe_i  (ad_oe_i),
    .ad_out_i (ad_out_i),
    .psp_oe_i (psp_oe_i),
    .psp_out_i(psp_out_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );

  assign pin_sync_o = pin_sync;

  AST_SLAVE_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off && slave) |-> (pad_out_o == psp_out_i && pad_oe_o == {W{psp_oe_i}})); // R8
  AST_RESET_INPUTS: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pad_oe_o == '0)); // R1
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic       clk = 0, rst_ni = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, pad_in = 8'h3C, pad_out, pad_oe;
  logic       ad_oe = 0, psp_oe = 0;
  logic [7:0] ad_out = 0, psp_out = 0, pin_sync;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .ad_oe_i(ad_oe), .ad_out_i(ad_out), .psp_oe_i(psp_oe), .psp_out_i(psp_out),
    .pin_sync_o(pin_sync)
  );

  // {we, addr, wdata-or-expected}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 2'd2, 8'hCF},  // R6 write direction
    {1'b0, 2'd2, 8'hCF},  // R6 read direction
    {1'b1, 2'd1, 8'hA5},  // R5 write latch
    {1'b0, 2'd1, 8'hA5},  // R3 latch read, not pins
    {1'b0, 2'd0, 8'h3C},  // R4 pin read
    {1'b1, 2'd0, 8'h5A},  // R5 write via pin address
    {1'b0, 2'd1, 8'h5A},  // R5 latch updated
    {1'b0, 2'd3, 8'h01}   // R10 control default
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    rd(2'd2, "R1 dir", 8'hFF);
    rd(2'd1, "R1 lat", 8'h00);
    rd(2'd3, "R1 ctl", 8'h01);
    chk("R1 pad_oe", pad_oe, 8'h00);

    foreach (VEC[i]) begin
      if (VEC[i][10]) wr(VEC[i][9:8], VEC[i][7:0]);
      else rd(VEC[i][9:8], $sformatf("R3/R4/R5/R6/R10 vec%0d", i), VEC[i][7:0]);
    end

    // R2 plain mode drive
    chk("R2 pad_oe", pad_oe, 8'h30);
    chk("R2 pad_out", pad_out, 8'h5A);

    // R4 two-edge delay
    @(negedge clk); pad_in = 8'h96; addr = 2'd0;
    @(negedge clk); chk("R4 one edge", rdata, 8'h3C);
    @(negedge clk); chk("R4 two edges", rdata, 8'h96);
    chk("R4 pin_sync", pin_sync, 8'h96);
    rd(2'd1, "R3 latch vs pins", 8'h5A);

    // R7 bus mode
    ad_oe = 1; ad_out = 8'hE7; psp_oe = 0; psp_out = 8'h81;
    wr(2'd3, 8'h00);
    chk("R7 bus oe", pad_oe, 8'hFF);
    chk("R7 bus out", pad_out, 8'hE7);
    rd(2'd2, "R7 dir kept", 8'hCF);
    rd(2'd1, "R7 lat kept", 8'h5A);
    // R9 bus beats slave
    wr(2'd3, 8'h02);
    chk("R9 bus out", pad_out, 8'hE7);
    chk("R9 bus oe", pad_oe, 8'hFF);
    // R8 slave mode
    wr(2'd3, 8'h03);
    chk("R8 slave oe off", pad_oe, 8'h00);
    @(negedge clk); psp_oe = 1; #1;
    chk("R8 slave oe on", pad_oe, 8'hFF);
    chk("R8 slave out", pad_out, 8'h81);
    rd(2'd3, "R10 ctl", 8'h03);
    wr(2'd3, 8'hFD);
    rd(2'd3, "R10 upper bits zero", 8'h01);
    chk("R2 back to plain", pad_oe, 8'h30);

    // R1 reset mid-run
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    rd(2'd2, "R1 dir after reset", 8'hFF);
    rd(2'd1, "R1 lat after reset", 8'h00);
    chk("R1 oe after reset", pad_oe, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule